// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a synchronous host and an external asynchronous static RAM with byte-wide data. The host posts one single-word read or write at a time through a valid/ready request port. The controller turns each request into a pin-level sequence on the RAM. That sequence uses two chip selects of opposite polarity, an active-low output enable and an active-low write strobe. Read data comes back on a one-cycle response pulse.

Every timing window is a whole number of system-clock cycles. The counts are derived at elaboration from the clock period and from the RAM's nanosecond limits, and each is rounded up with a floor of one cycle. The limits cover address set-up, strobe width, data set-up before the strobe ends, write recovery, total write cycle, access time and the delay before the RAM releases the bus. The controller never drives the data bus itself. It presents the write value together with a tristate enable, and the pad logic merges these with the RAM's returned data.

Back-pressure rules: `req_ready` is high only while the controller is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The host must hold `req_valid` and the request fields steady until that edge. The response has no ready signal, so the host must take `rsp_rdata` in the cycle where `rsp_valid` is high.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is high, and in the first idle cycle after it, both chip selects are inactive (`ram_ce_n`=1, `ram_ce2`=0), `ram_we_n`=1, `ram_oe_n`=1, `ram_dq_oe`=0 and `rsp_valid`=0. After reset is released, `req_ready`=1.
- R2: A write selects the chip for exactly SET_CYC cycles with the strobe high. It then holds `ram_we_n` low for exactly WP_CYC consecutive cycles, then keeps the chip selected with the strobe high for exactly REC_CYC cycles before deselecting. Whenever `ram_we_n` is low, the chip is selected.
- R3: While `ram_we_n` stays low, `ram_addr` and `ram_dq_o` do not change.
- R4: `ram_dq_oe` is high only while `ram_we_n` is low and the chip is selected, and never in the first strobe cycle. Every write strobe has at least one driven cycle, and the strobe ends with the value that was driven.
- R5: A read holds `ram_oe_n` low, with `ram_we_n` high and the chip selected, for exactly RD_CYC cycles. `rsp_valid` pulses in the cycle after the last of these.
- R6: After each read, the chip stays deselected with `ram_oe_n` high for exactly TRN_CYC cycles before `req_ready` returns. `ram_dq_oe` is never high while the RAM may still be driving the bus.
- R7: `req_ready` is high only while the chip is deselected with both enables high. A request held during a busy period is taken only once the controller is idle again.
- R8: `ram_we_n` and `ram_oe_n` are never low together.
- R9: Exactly one `rsp_valid` pulse occurs per accepted read, and none occurs for a write.
- R10: `rsp_rdata` equals the RAM data present on `ram_dq_i` in the last access cycle. A read therefore returns the value most recently written to that address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle pulse carrying read data |
| rsp_rdata | output | DATA_W | Read data |
| ram_addr | output | ADDR_W | RAM address pins |
| ram_dq_o | output | DATA_W | Value driven on the RAM data bus |
| ram_dq_oe | output | 1 | Tristate enable for `ram_dq_o` |
| ram_dq_i | input | DATA_W | Value seen on the RAM data bus |
| ram_ce_n | output | 1 | Active-low chip select |
| ram_ce2 | output | 1 | Active-high chip select |
| ram_we_n | output | 1 | Active-low write strobe |
| ram_oe_n | output | 1 | Active-low output enable |

## Verification
A sequencer that stalls or skips a phase shows up within the same access. The strobe, set-up, recovery, output-enable or turnaround run at the pins is then one or more cycles longer or shorter than expected, and it is measured the cycle that run ends. A wrong counter load or sampling point corrupts the returned byte: the bench's RAM model returns the inverted value until the access time has passed, so an early capture appears on the very next response. A driver-enable fault shows up within the cycle it occurs, as bus contention against the modelled RAM or as data missing at the strobe's rising edge. A lost write is caught by the later readback sweep.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSET,
    ST_WSTB,
    ST_WREC,
    ST_RACC,
    ST_TURN
  } seq_state_e;

  // Whole clock cycles covering a time in picoseconds, never below one.
  function automatic int unsigned cyc_of(input int unsigned t_ps, input int unsigned clk_ps);
    int unsigned n;
    n = (t_ps + clk_ps - 1) / clk_ps;
    return (n < 1) ? 1 : n;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 18,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned SET_CYC = 1,
  parameter int unsigned WP_CYC  = 5,
  parameter int unsigned REC_CYC = 1,
  parameter int unsigned RD_CYC  = 6,
  parameter int unsigned TRN_CYC = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output seq_state_e        state_q,
  output seq_state_e        state_d,
  output logic              last,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q
);

  localparam int unsigned MAXC  = max2(max2(max2(SET_CYC, WP_CYC), max2(REC_CYC, RD_CYC)), TRN_CYC);
  localparam int unsigned CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign last      = (cnt_q == '0);
  assign req_ready = (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    cnt_d   = last ? cnt_q : cnt_q - 1'b1;
    unique case (state_q)
      ST_IDLE: if (req_valid) begin
        if (req_write) begin
          state_d = ST_WSET;
          cnt_d   = CNT_W'(SET_CYC - 1);
        end else begin
          state_d = ST_RACC;
          cnt_d   = CNT_W'(RD_CYC - 1);
        end
      end
      ST_WSET: if (last) begin
        state_d = ST_WSTB;
        cnt_d   = CNT_W'(WP_CYC - 1);
      end
      ST_WSTB: if (last) begin
        state_d = ST_WREC;
        cnt_d   = CNT_W'(REC_CYC - 1);
      end
      ST_WREC: if (last) state_d = ST_IDLE;
      ST_RACC: if (last) begin
        state_d = ST_TURN;
        cnt_d   = CNT_W'(TRN_CYC - 1);
      end
      ST_TURN: if (last) state_d = ST_IDLE;
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (req_ready && req_valid) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
    end
  end

endmodule

// File: rtl/sram_ctrl_pins.sv
module sram_ctrl_pins
  import sram_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  seq_state_e state_q,
  input  seq_state_e state_d,
  output logic       ram_ce_n,
  output logic       ram_ce2,
  output logic       ram_we_n,
  output logic       ram_oe_n,
  output logic       ram_dq_oe
);

  logic sel_d;
  assign sel_d = (state_d != ST_IDLE) && (state_d != ST_TURN);

  // Pins are registered from the next state so they carry no decode glitches.
  always_ff @(posedge clk) begin
    if (rst) begin
      ram_ce_n  <= 1'b1;
      ram_ce2   <= 1'b0;
      ram_we_n  <= 1'b1;
      ram_oe_n  <= 1'b1;
      ram_dq_oe <= 1'b0;
    end else begin
      ram_ce_n  <= ~sel_d;
      ram_ce2   <= sel_d;
      ram_we_n  <= ~(state_d == ST_WSTB);
      ram_oe_n  <= ~(state_d == ST_RACC);
      // Driver on from the second strobe cycle, off with the strobe's rise.
      ram_dq_oe <= (state_d == ST_WSTB) && (state_q == ST_WSTB);
    end
  end

endmodule

// File: rtl/sram_ctrl_rdcap.sv
module sram_ctrl_rdcap
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_state_e        state_q,
  input  logic              last,
  input  logic [DATA_W-1:0] ram_dq_i,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic take;
  assign take = (state_q == ST_RACC) && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= take;
      if (take) rsp_rdata <= ram_dq_i;
    end
  end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 18,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned CLK_PS   = 8000,
  parameter int unsigned T_AS_PS  = 0,
  parameter int unsigned T_WP_PS  = 35000,
  parameter int unsigned T_DW_PS  = 25000,
  parameter int unsigned T_WR_PS  = 0,
  parameter int unsigned T_WC_PS  = 45000,
  parameter int unsigned T_AA_PS  = 45000,
  parameter int unsigned T_OE_PS  = 20000,
  parameter int unsigned T_OFF_PS = 20000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_dq_o,
  output logic              ram_dq_oe,
  input  logic [DATA_W-1:0] ram_dq_i,
  output logic              ram_ce_n,
  output logic              ram_ce2,
  output logic              ram_we_n,
  output logic              ram_oe_n
);

  localparam int unsigned SET_CYC = cyc_of(T_AS_PS, CLK_PS);
  // One undriven strobe cycle precedes the data set-up window.
  localparam int unsigned WP_CYC  = max2(cyc_of(T_WP_PS, CLK_PS), cyc_of(T_DW_PS, CLK_PS) + 1);
  localparam int unsigned WC_CYC  = cyc_of(T_WC_PS, CLK_PS);
  localparam int unsigned REC_CYC = (WC_CYC > SET_CYC + WP_CYC)
                                    ? max2(cyc_of(T_WR_PS, CLK_PS), WC_CYC - SET_CYC - WP_CYC)
                                    : cyc_of(T_WR_PS, CLK_PS);
  localparam int unsigned RD_CYC  = max2(cyc_of(T_AA_PS, CLK_PS), cyc_of(T_OE_PS, CLK_PS));
  localparam int unsigned TRN_CYC = cyc_of(T_OFF_PS, CLK_PS);

  seq_state_e state_q, state_d;
  logic       last;

  sram_ctrl_seq #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SET_CYC(SET_CYC),
    .WP_CYC (WP_CYC),
    .REC_CYC(REC_CYC),
    .RD_CYC (RD_CYC),
    .TRN_CYC(TRN_CYC)
  ) seq_i (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .req_ready(req_ready),
    .state_q  (state_q),
    .state_d  (state_d),
    .last     (last),
    .addr_q   (ram_addr),
    .wdata_q  (ram_dq_o)
  );

  sram_ctrl_pins pins_i (
    .clk      (clk),
    .rst      (rst),
    .state_q  (state_q),
    .state_d  (state_d),
    .ram_ce_n (ram_ce_n),
    .ram_ce2  (ram_ce2),
    .ram_we_n (ram_we_n),
    .ram_oe_n (ram_oe_n),
    .ram_dq_oe(ram_dq_oe)
  );

  sram_ctrl_rdcap #(.DATA_W(DATA_W)) rdcap_i (
    .clk      (clk),
    .rst      (rst),
    .state_q  (state_q),
    .last     (last),
    .ram_dq_i (ram_dq_i),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
  );

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] ram_addr,
  input logic [DATA_W-1:0] ram_dq_o,
  input logic              ram_dq_oe,
  input logic              ram_ce_n,
  input logic              ram_ce2,
  input logic              ram_we_n,
  input logic              ram_oe_n
);

  assert_strobe_selected_R2: assert property (@(posedge clk) disable iff (rst)
    !ram_we_n |-> (!ram_ce_n && ram_ce2));

  assert_addr_data_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!ram_we_n && $past(!ram_we_n)) |-> ($stable(ram_addr) && $stable(ram_dq_o)));

  assert_drive_inside_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    ram_dq_oe |-> (!ram_we_n && $past(!ram_we_n)));

  assert_rsp_after_read_R5: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($past(!ram_oe_n) && ram_oe_n));

  assert_ready_deselected_R7: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (ram_ce_n && !ram_ce2 && ram_we_n && ram_oe_n));

  assert_enables_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    !(!ram_we_n && !ram_oe_n));

endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .ram_addr (ram_addr),
  .ram_dq_o (ram_dq_o),
  .ram_dq_oe(ram_dq_oe),
  .ram_ce_n (ram_ce_n),
  .ram_ce2  (ram_ce2),
  .ram_we_n (ram_we_n),
  .ram_oe_n (ram_oe_n)
);

// File: tb/sram_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_ctrl_tb_top;

  localparam int AW     = 6;
  localparam int DEPTH  = 1 << AW;
  localparam int CLK_PS = 8000;
  // Expected cycle counts from the timing limits at 125 MHz.
  localparam int SET_EXP = 1;
  localparam int WP_A    = (35000 + CLK_PS - 1) / CLK_PS;
  localparam int WP_B    = (25000 + CLK_PS - 1) / CLK_PS + 1;
  localparam int WP_EXP  = (WP_A > WP_B) ? WP_A : WP_B;
  localparam int WC_EXP  = (45000 + CLK_PS - 1) / CLK_PS;
  localparam int REC_EXP = (WC_EXP - SET_EXP - WP_EXP > 1) ? WC_EXP - SET_EXP - WP_EXP : 1;
  localparam int RD_EXP  = (45000 + CLK_PS - 1) / CLK_PS;
  localparam int TRN_EXP = (20000 + CLK_PS - 1) / CLK_PS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_wdata = '0;
  logic          req_ready, rsp_valid, ram_dq_oe, ram_ce_n, ram_ce2, ram_we_n, ram_oe_n;
  logic [7:0]    rsp_rdata, ram_dq_o;
  logic [7:0]    ram_dq_i = 8'h00;
  logic [AW-1:0] ram_addr;

  sram_ctrl #(.ADDR_W(AW), .DATA_W(8), .CLK_PS(CLK_PS)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ram_addr(ram_addr),
    .ram_dq_o(ram_dq_o), .ram_dq_oe(ram_dq_oe), .ram_dq_i(ram_dq_i),
    .ram_ce_n(ram_ce_n), .ram_ce2(ram_ce2), .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n)
  );

  int tests = 0, fails = 0, reads_issued = 0, rsp_seen = 0;
  logic [7:0] mem [DEPTH];
  logic [7:0] exp_mem [DEPTH];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // RAM model and pin monitor, evaluated away from the active edge.
  bit            prev_we = 1'b1, prev_dqoe = 1'b0, in_rec = 1'b0, in_turn = 1'b0, capv = 1'b0;
  logic [AW-1:0] prev_addr = '0;
  logic [7:0]    prev_dq = '0, cap = '0;
  int            we_run = 0, pre_cnt = 0, rec_cnt = 0, oe_run = 0, hold = 0, turn_cnt = 0;

  always @(negedge clk) begin
    bit sel, we_fall, we_rise, oe_rise;
    if (!rst) begin
      sel     = !ram_ce_n && ram_ce2;
      we_fall = !ram_we_n && prev_we;
      we_rise = ram_we_n && !prev_we;
      oe_rise = ram_oe_n && (oe_run != 0);
      check(!(!ram_we_n && !ram_oe_n), "R8 both enables low", {ram_we_n, ram_oe_n}, 2'b11);
      check(!(req_ready && sel), "R7 ready while selected", req_ready, 0);
      check(!(ram_dq_oe && (ram_we_n || prev_we || !sel)), "R4 driver outside strobe", ram_dq_oe, 0);
      check(!(ram_dq_oe && ((sel && !ram_oe_n) || hold > 0)), "R6 bus contention", ram_dq_oe, 0);
      if (hold > 0) hold--;
      if (!ram_we_n) begin
        check(sel, "R2 strobe while deselected", sel, 1);
        if (!prev_we) begin
          check(ram_addr == prev_addr, "R3 address moved in strobe", ram_addr, prev_addr);
          if (ram_dq_oe && prev_dqoe)
            check(ram_dq_o == prev_dq, "R3 data moved in strobe", ram_dq_o, prev_dq);
        end
        we_run++;
        if (ram_dq_oe) begin cap = ram_dq_o; capv = 1'b1; end
      end
      if (we_fall) begin
        check(pre_cnt == SET_EXP, "R2 setup cycles", pre_cnt, SET_EXP);
        pre_cnt = 0;
      end
      if (we_rise) begin
        check(we_run == WP_EXP, "R2 strobe width", we_run, WP_EXP);
        check(capv, "R4 strobe never driven", capv, 1);
        mem[prev_addr] = cap;
        we_run = 0; capv = 1'b0; in_rec = 1'b1; rec_cnt = 0;
      end
      if (in_rec) begin
        if (sel && ram_we_n) rec_cnt++;
        else begin
          check(rec_cnt == REC_EXP, "R2 recovery cycles", rec_cnt, REC_EXP);
          in_rec = 1'b0;
        end
      end
      if (sel && ram_we_n && ram_oe_n && !in_rec) pre_cnt++;
      if (!sel) pre_cnt = 0;
      if (sel && !ram_oe_n && ram_we_n) begin
        oe_run++;
        ram_dq_i = (oe_run >= RD_EXP) ? mem[ram_addr] : ~mem[ram_addr];
      end else begin
        ram_dq_i = 8'h00;
      end
      if (oe_rise) begin
        check(oe_run == RD_EXP, "R5 output-enable width", oe_run, RD_EXP);
        oe_run = 0; hold = TRN_EXP; in_turn = 1'b1; turn_cnt = 0;
      end
      if (in_turn) begin
        if (!req_ready) begin
          check(!sel && ram_oe_n, "R6 selected in turnaround", sel, 0);
          turn_cnt++;
        end else begin
          check(turn_cnt == TRN_EXP, "R6 turnaround cycles", turn_cnt, TRN_EXP);
          in_turn = 1'b0;
        end
      end
      if (rsp_valid) rsp_seen++;
      prev_we = ram_we_n; prev_addr = ram_addr; prev_dq = ram_dq_o; prev_dqoe = ram_dq_oe;
    end
  end

  // Request is raised at once and held until an idle edge takes it (R7).
  task automatic issue(input bit w, input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d);
    issue(1'b1, a, d);
    exp_mem[a] = d;
  endtask

  task automatic do_read(input logic [AW-1:0] a);
    issue(1'b0, a, 8'h00);
    reads_issued++;
    while (!rsp_valid) @(negedge clk);
    check(rsp_rdata == exp_mem[a], "R10 read data", rsp_rdata, exp_mem[a]);
  endtask

  function automatic logic [7:0] pat(input int a, input int k);
    return 8'((a * 29 + 7 + k * 83) & 8'hFF);
  endfunction

  bit done = 1'b0;

  initial begin
    for (int i = 0; i < DEPTH; i++) begin mem[i] = 8'h00; exp_mem[i] = 8'h00; end
    repeat (3) @(negedge clk);
    check(ram_ce_n && !ram_ce2 && ram_we_n && ram_oe_n && !ram_dq_oe && !rsp_valid,
          "R1 pins in reset", {ram_ce_n, ram_ce2, ram_we_n, ram_oe_n, ram_dq_oe, rsp_valid}, 6'b101100);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready, "R1 ready after reset", req_ready, 1);
    check(ram_ce_n && !ram_ce2 && !ram_dq_oe, "R1 idle deselected", {ram_ce_n, ram_ce2, ram_dq_oe}, 3'b100);
    // Full write sweep, then reverse readback.
    for (int a = 0; a < DEPTH; a++) do_write(AW'(a), pat(a, 0));
    check(rsp_seen == 0, "R9 no response for writes", rsp_seen, 0);
    for (int a = DEPTH - 1; a >= 0; a--) do_read(AW'(a));
    // Interleaved write-then-read and read-then-write orders.
    for (int a = 0; a < DEPTH; a += 3) begin
      do_write(AW'(a), pat(a, 1));
      do_read(AW'(a));
      do_read(AW'(DEPTH - 1 - a));
      do_write(AW'(DEPTH - 1 - a), pat(a, 2));
    end
    // Repeated writes to one address: last value wins.
    do_write(AW'(5), 8'h00);
    do_write(AW'(5), 8'hFF);
    do_read(AW'(5));
    do_write(AW'(DEPTH - 1), 8'h5A);
    do_read(AW'(DEPTH - 1));
    do_read(AW'(0));
    repeat (TRN_EXP + 4) @(negedge clk);
    check(rsp_seen == reads_issued, "R9 one response per read", rsp_seen, reads_issued);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule